// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Unit

This block holds the transmit and receive queues of an SPI controller and turns their fill levels into interrupt requests. The bus side pushes transmit words and pops received words. The serial shift engine pops transmit words and pushes received words. Both queues share a fixed byte budget, so the number of entries depends on the configured word width. Changing the width empties both queues.

Each direction has a 2-bit threshold selector. The transmit and receive interrupt outputs are registered levels, recomputed on every clock from the current fill level, the selector and, for one transmit condition, whether the shifter is busy. Three sticky error flags are kept: receive overflow, transmit underrun (framed operation only), and frame error. Each flag has its own enable, and the enabled flags are combined into one fault interrupt. A 32-bit status word reports both fill levels, the receive-empty flag and the three error flags.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Queue capacity is FIFO_BYTES entries when cfg_width is 0 (8-bit words), FIFO_BYTES/2 when it is 1 (16-bit), and FIFO_BYTES/4 when it is 2 or 3 (32-bit). A push into a full queue is dropped and leaves the level unchanged.
- R2: Words come out in the order they went in. Each stored word is masked to the configured width: 8, 16 or 32 low bits.
- R3: The status word holds the receive-empty flag at bit 5, the overflow flag at bit 6, the underrun flag at bit 8, the frame-error flag at bit 12, the transmit level at bits 20:16 and the receive level at bits 28:24. All other bits are 0.
- R4: irq_rx follows cfg_rx_sel: 0 means the queue is empty, 1 means it is not empty, 2 means the level is at least half the capacity, 3 means the level equals the capacity.
- R5: irq_tx follows cfg_tx_sel: 0 means the queue is empty and sh_busy is low, 1 means the queue is empty, 2 means at least half the capacity is free, 3 means at least one entry is free.
- R6: The interrupt outputs are registered. They reflect a level change one clock after the status word shows it, and they are 0 during reset.
- R7: A shifter push into a full receive queue drops the word, keeps the older contents, and sets the overflow flag. The flag stays set until clr_ovfl is pulsed.
- R8: A shifter pop from an empty transmit queue sets the underrun flag only while cfg_framed is 1. The flag stays set until clr_urun is pulsed.
- R9: A pulse on sh_multi_sync sets the frame-error flag. The flag stays set until clr_ferr is pulsed.
- R10: irq_fault is high exactly when some error flag is set and its own enable (en_ovfl, en_urun, en_ferr) is high.
- R11: A pop from an empty queue leaves the level at 0. The read data keeps showing the last word popped.
- R12: A change of cfg_width empties both queues on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Word width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cfg_tx_sel | input | 2 | Transmit interrupt threshold selector |
| cfg_rx_sel | input | 2 | Receive interrupt threshold selector |
| cfg_framed | input | 1 | Framed operation; allows underrun detection |
| en_urun | input | 1 | Underrun flag enable for the fault interrupt |
| en_ovfl | input | 1 | Overflow flag enable for the fault interrupt |
| en_ferr | input | 1 | Frame-error flag enable for the fault interrupt |
| clr_urun | input | 1 | Clear strobe for the underrun flag |
| clr_ovfl | input | 1 | Clear strobe for the overflow flag |
| clr_ferr | input | 1 | Clear strobe for the frame-error flag |
| bus_tx_push | input | 1 | Bus-side push into the transmit queue |
| bus_tx_data | input | 32 | Word pushed by the bus |
| bus_rx_pop | input | 1 | Bus-side pop from the receive queue |
| bus_rx_data | output | 32 | Head of the receive queue |
| sh_tx_pop | input | 1 | Shifter pop from the transmit queue |
| sh_tx_data | output | 32 | Head of the transmit queue |
| sh_rx_push | input | 1 | Shifter push into the receive queue |
| sh_rx_data | input | 32 | Word pushed by the shifter |
| sh_busy | input | 1 | Shift register holds a word in flight |
| sh_multi_sync | input | 1 | Pulse: more than one frame sync seen |
| status | output | 32 | Status word |
| irq_tx | output | 1 | Transmit threshold interrupt |
| irq_rx | output | 1 | Receive threshold interrupt |
| irq_fault | output | 1 | Shared fault interrupt |

## Verification
The bench builds the block with its default byte budget of 16. It then switches cfg_width at run time, so the same netlist is exercised at capacities of 16, 8 and 4 entries. This reaches the half and full thresholds at three different depths, the unused width code, and the flush that a width change causes while the queues still hold data. Overflow and the full-queue drop are exercised at the smallest depth, where five pushes are enough to pass the limit.

// File: rtl/sfti_pkg.sv
package sfti_pkg;
  localparam int WORD_W = 32;

  // status word layout
  localparam int ST_RX_EMPTY = 5;
  localparam int ST_OVFL     = 6;
  localparam int ST_URUN     = 8;
  localparam int ST_FERR     = 12;
  localparam int ST_TXLVL_LO = 16;
  localparam int ST_RXLVL_LO = 24;
  localparam int ST_LVL_W    = 5;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_ALT  = 2'd3
  } wid_e;

  // entries that fit into the byte budget for a given width code
  function automatic int unsigned entries_for(input int unsigned bytes, input logic [1:0] w);
    case (w)
      WID_BYTE: return bytes;
      WID_HALF: return bytes / 2;
      default:  return bytes / 4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] w);
    case (w)
      WID_BYTE: return 32'h0000_00FF;
      WID_HALF: return 32'h0000_FFFF;
      default:  return 32'hFFFF_FFFF;
    endcase
  endfunction

  // receive threshold condition
  function automatic logic rx_hit(input logic [1:0] sel, input int unsigned lvl,
                                  input int unsigned cap);
    case (sel)
      2'd0:    return lvl == 0;
      2'd1:    return lvl != 0;
      2'd2:    return lvl >= cap / 2;
      default: return lvl >= cap;
    endcase
  endfunction

  // transmit threshold condition
  function automatic logic tx_hit(input logic [1:0] sel, input int unsigned lvl,
                                  input int unsigned cap, input logic busy);
    case (sel)
      2'd0:    return (lvl == 0) && !busy;
      2'd1:    return lvl == 0;
      2'd2:    return (lvl + cap / 2) <= cap;
      default: return lvl < cap;
    endcase
  endfunction
endpackage

// File: rtl/sfti_fifo.sv
module sfti_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [$clog2(DEPTH+1)-1:0]   cap,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty,
  output logic                         drop_evt,
  output logic                         uflow_evt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic [DW-1:0] last_q;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [LW-1:0] c);
    return (LW'(p) == c - LW'(1)) ? '0 : p + AW'(1);
  endfunction

  assign empty     = (cnt == '0);
  assign full      = (cnt >= cap);
  assign pop_ok    = pop && !empty;
  assign push_ok   = push && (!full || pop_ok);
  assign drop_evt  = push && !push_ok && !flush;
  assign uflow_evt = pop && empty && !flush;
  assign level     = cnt;
  assign rdata     = empty ? last_q : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      last_q <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= adv(wptr, cap);
      if (pop_ok) begin
        rptr   <= adv(rptr, cap);
        last_q <= mem[rptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_LEVEL_IN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (level <= cap)); // R1
  AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !pop) |=> (level == $past(level))); // R1
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_evt && !push) |=> (empty && rdata == $past(rdata))); // R11
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R12
endmodule

// File: rtl/sfti_irq_eval.sv
module sfti_irq_eval #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    tx_sel,
  input  logic [1:0]    rx_sel,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] cap,
  input  logic          busy,
  output logic          irq_tx,
  output logic          irq_rx
);
  import sfti_pkg::*;

  logic tx_cond, rx_cond;

  assign tx_cond = tx_hit(tx_sel, 32'(tx_lvl), 32'(cap), busy);
  assign rx_cond = rx_hit(rx_sel, 32'(rx_lvl), 32'(cap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      irq_tx <= tx_cond;
      irq_rx <= rx_cond;
    end
  end

  AST_TX_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == 2'd0 && busy) |=> !irq_tx); // R5
  AST_RX_FULL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel == 2'd3 && rx_lvl == cap) |=> irq_rx); // R4
endmodule

// File: rtl/sfti_err_flags.sv
module sfti_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic framed,
  input  logic ovfl_evt,
  input  logic urun_evt,
  input  logic ferr_evt,
  input  logic clr_ovfl,
  input  logic clr_urun,
  input  logic clr_ferr,
  input  logic en_ovfl,
  input  logic en_urun,
  input  logic en_ferr,
  output logic ovfl,
  output logic urun,
  output logic ferr,
  output logic fault
);
  logic urun_set;

  assign urun_set = urun_evt && framed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfl <= 1'b0;
      urun <= 1'b0;
      ferr <= 1'b0;
    end else begin
      if (ovfl_evt)      ovfl <= 1'b1;
      else if (clr_ovfl) ovfl <= 1'b0;
      if (urun_set)      urun <= 1'b1;
      else if (clr_urun) urun <= 1'b0;
      if (ferr_evt)      ferr <= 1'b1;
      else if (clr_ferr) ferr <= 1'b0;
    end
  end

  assign fault = (ovfl && en_ovfl) || (urun && en_urun) || (ferr && en_ferr);

  AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl && !clr_ovfl) |=> ovfl); // R7
  AST_URUN_NEEDS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun) |-> $past(framed)); // R8
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !clr_ferr) |=> ferr); // R9
  AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ovfl && !en_urun && !en_ferr) |-> !fault); // R10
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
  parameter int FIFO_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_width,
  input  logic [1:0]  cfg_tx_sel,
  input  logic [1:0]  cfg_rx_sel,
  input  logic        cfg_framed,
  input  logic        en_urun,
  input  logic        en_ovfl,
  input  logic        en_ferr,
  input  logic        clr_urun,
  input  logic        clr_ovfl,
  input  logic        clr_ferr,
  input  logic        bus_tx_push,
  input  logic [31:0] bus_tx_data,
  input  logic        bus_rx_pop,
  output logic [31:0] bus_rx_data,
  input  logic        sh_tx_pop,
  output logic [31:0] sh_tx_data,
  input  logic        sh_rx_push,
  input  logic [31:0] sh_rx_data,
  input  logic        sh_busy,
  input  logic        sh_multi_sync,
  output logic [31:0] status,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_fault
);
  import sfti_pkg::*;

  localparam int LW = $clog2(FIFO_BYTES + 1);

  logic [1:0]    width_q;
  logic          width_chg;
  logic [LW-1:0] cap;
  logic [31:0]   mask;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_drop_evt, tx_uflow_evt, rx_drop_evt, rx_uflow_evt;
  logic          f_ovfl, f_urun, f_ferr;

  assign cap       = LW'(entries_for(FIFO_BYTES, cfg_width));
  assign mask      = width_mask(cfg_width);
  assign width_chg = (cfg_width != width_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= 2'd0;
    else        width_q <= cfg_width;
  end

  sfti_fifo #(.DEPTH(FIFO_BYTES), .DW(WORD_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(width_chg), .cap(cap),
    .push(bus_tx_push), .wdata(bus_tx_data & mask),
    .pop(sh_tx_pop), .rdata(sh_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .drop_evt(tx_drop_evt), .uflow_evt(tx_uflow_evt)
  );

  sfti_fifo #(.DEPTH(FIFO_BYTES), .DW(WORD_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(width_chg), .cap(cap),
    .push(sh_rx_push), .wdata(sh_rx_data & mask),
    .pop(bus_rx_pop), .rdata(bus_rx_data),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .drop_evt(rx_drop_evt), .uflow_evt(rx_uflow_evt)
  );

  sfti_irq_eval #(.LW(LW)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_sel(cfg_tx_sel), .rx_sel(cfg_rx_sel),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .cap(cap), .busy(sh_busy),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  sfti_err_flags u_err (
    .clk(clk), .rst_n(rst_n), .framed(cfg_framed),
    .ovfl_evt(rx_drop_evt), .urun_evt(tx_uflow_evt), .ferr_evt(sh_multi_sync),
    .clr_ovfl(clr_ovfl), .clr_urun(clr_urun), .clr_ferr(clr_ferr),
    .en_ovfl(en_ovfl), .en_urun(en_urun), .en_ferr(en_ferr),
    .ovfl(f_ovfl), .urun(f_urun), .ferr(f_ferr), .fault(irq_fault)
  );

  always_comb begin
    status = '0;
    status[ST_RX_EMPTY] = rx_empty;
    status[ST_OVFL]     = f_ovfl;
    status[ST_URUN]     = f_urun;
    status[ST_FERR]     = f_ferr;
    status[ST_TXLVL_LO +: ST_LVL_W] = ST_LVL_W'(tx_lvl);
    status[ST_RXLVL_LO +: ST_LVL_W] = ST_LVL_W'(rx_lvl);
  end

  AST_WIDTH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    width_chg |=> (tx_lvl == '0 && rx_lvl == '0)); // R12
  AST_TX_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drop_evt && !sh_tx_pop) |=> (tx_lvl == $past(tx_lvl))); // R1
  AST_RX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop_evt && tx_full) |=> status[ST_OVFL]); // R7
  AST_RX_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_uflow_evt && !sh_rx_push && rx_full == 1'b0) |=> (rx_lvl == '0)); // R11
endmodule

// File: tb/tb_spi_fifo_irq_unit.sv
module tb_spi_fifo_irq_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_width = 2'd0, cfg_tx_sel = 2'd0, cfg_rx_sel = 2'd0;
  logic cfg_framed = 0, en_urun = 0, en_ovfl = 0, en_ferr = 0;
  logic clr_urun = 0, clr_ovfl = 0, clr_ferr = 0;
  logic bus_tx_push = 0, bus_rx_pop = 0, sh_tx_pop = 0, sh_rx_push = 0;
  logic sh_busy = 0, sh_multi_sync = 0;
  logic [31:0] bus_tx_data = '0, sh_rx_data = '0;
  logic [31:0] bus_rx_data, sh_tx_data, status;
  logic irq_tx, irq_rx, irq_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_fifo_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_tx_sel(cfg_tx_sel),
    .cfg_rx_sel(cfg_rx_sel), .cfg_framed(cfg_framed), .en_urun(en_urun),
    .en_ovfl(en_ovfl), .en_ferr(en_ferr), .clr_urun(clr_urun), .clr_ovfl(clr_ovfl),
    .clr_ferr(clr_ferr), .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
    .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data), .sh_tx_pop(sh_tx_pop),
    .sh_tx_data(sh_tx_data), .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
    .sh_busy(sh_busy), .sh_multi_sync(sh_multi_sync), .status(status),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_fault(irq_fault)
  );

  // vector: width, tx_sel, rx_sel, n_tx, n_rx, busy, exp_irq_tx, exp_irq_rx
  localparam logic [18:0] VEC [14] = '{
    {2'd0, 2'd0, 2'd0, 5'd0,  5'd0,  1'b0, 1'b1, 1'b1},
    {2'd0, 2'd0, 2'd1, 5'd0,  5'd0,  1'b1, 1'b0, 1'b0},
    {2'd0, 2'd1, 2'd1, 5'd0,  5'd3,  1'b1, 1'b1, 1'b1},
    {2'd0, 2'd2, 2'd2, 5'd8,  5'd8,  1'b0, 1'b1, 1'b1},
    {2'd0, 2'd2, 2'd2, 5'd9,  5'd7,  1'b0, 1'b0, 1'b0},
    {2'd0, 2'd3, 2'd3, 5'd16, 5'd16, 1'b0, 1'b0, 1'b1},
    {2'd0, 2'd3, 2'd3, 5'd15, 5'd15, 1'b0, 1'b1, 1'b0},
    {2'd1, 2'd3, 2'd3, 5'd8,  5'd8,  1'b0, 1'b0, 1'b1},
    {2'd1, 2'd2, 2'd2, 5'd4,  5'd3,  1'b0, 1'b1, 1'b0},
    {2'd2, 2'd2, 2'd2, 5'd3,  5'd2,  1'b0, 1'b0, 1'b1},
    {2'd2, 2'd3, 2'd3, 5'd6,  5'd6,  1'b0, 1'b0, 1'b1},
    {2'd2, 2'd1, 2'd0, 5'd1,  5'd0,  1'b0, 1'b0, 1'b1},
    {2'd3, 2'd3, 2'd2, 5'd4,  5'd4,  1'b0, 1'b0, 1'b1},
    {2'd1, 2'd0, 2'd1, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0}
  };

  function automatic int cap_of(input logic [1:0] w);
    if (w == 2'd0) return 16;
    if (w == 2'd1) return 8;
    return 4;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic push_rx(input logic [31:0] d);
    sh_rx_data = d; sh_rx_push = 1; tick(1); sh_rx_push = 0;
  endtask

  task automatic push_tx(input logic [31:0] d);
    bus_tx_data = d; bus_tx_push = 1; tick(1); bus_tx_push = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // reset state
    tick(1);
    check("R3 reset status", status, 32'h0000_0020);
    check("R6 reset irq_tx", {31'd0, irq_tx}, 32'd0);
    check("R6 reset irq_rx", {31'd0, irq_rx}, 32'd0);
    rst_n = 1; tick(2);
    check("R5 sel0 idle empty", {31'd0, irq_tx}, 32'd1);
    check("R4 sel0 empty", {31'd0, irq_rx}, 32'd1);

    // table walk
    for (int v = 0; v < 14; v++) begin
      int ntx, nrx, cap, steps;
      rst_n = 0;
      cfg_width  = VEC[v][18:17];
      cfg_tx_sel = VEC[v][16:15];
      cfg_rx_sel = VEC[v][14:13];
      ntx = int'(VEC[v][12:8]);
      nrx = int'(VEC[v][7:3]);
      sh_busy = VEC[v][2];
      cap = cap_of(cfg_width);
      tick(2); rst_n = 1; tick(2);
      steps = (ntx > nrx) ? ntx : nrx;
      for (int i = 0; i < steps; i++) begin
        bus_tx_push = (i < ntx);
        sh_rx_push  = (i < nrx);
        bus_tx_data = 32'(i + 1);
        sh_rx_data  = 32'(i + 100);
        tick(1);
      end
      bus_tx_push = 0; sh_rx_push = 0;
      tick(2);
      check($sformatf("R1 tx level v%0d", v), {27'd0, status[20:16]}, 32'((ntx < cap) ? ntx : cap));
      check($sformatf("R1 rx level v%0d", v), {27'd0, status[28:24]}, 32'((nrx < cap) ? nrx : cap));
      check($sformatf("R3 rx empty v%0d", v), {31'd0, status[5]}, 32'(nrx == 0));
      check($sformatf("R5 irq_tx v%0d", v), {31'd0, irq_tx}, {31'd0, VEC[v][1]});
      check($sformatf("R4 irq_rx v%0d", v), {31'd0, irq_rx}, {31'd0, VEC[v][0]});
    end

    // clean start for directed tests
    rst_n = 0; sh_busy = 0; cfg_width = 0; cfg_tx_sel = 0; cfg_rx_sel = 1;
    tick(2); rst_n = 1; tick(2);

    // R6: registered interrupt lags the status word by one clock
    check("R6 rx idle", {31'd0, irq_rx}, 32'd0);
    push_rx(32'h11);
    check("R6 level visible", {27'd0, status[28:24]}, 32'd1);
    check("R6 irq one clock later", {31'd0, irq_rx}, 32'd0);
    tick(1);
    check("R6 irq asserted", {31'd0, irq_rx}, 32'd1);

    // R2: order and masking
    check("R2 rx head 8b", bus_rx_data, 32'h11);
    bus_rx_pop = 1; tick(1); bus_rx_pop = 0;
    cfg_width = 1; tick(2);
    push_rx(32'h1234_5678);
    check("R2 16b mask", bus_rx_data, 32'h0000_5678);
    cfg_width = 2; tick(1);
    check("R12 rx flushed", {27'd0, status[28:24]}, 32'd0);
    tick(1);
    push_rx(32'hCAFE_F00D);
    push_rx(32'h0102_0304);
    check("R2 32b first", bus_rx_data, 32'hCAFE_F00D);
    bus_rx_pop = 1; tick(1);
    check("R2 32b second", bus_rx_data, 32'h0102_0304);
    tick(1);
    check("R11 empty shows last", bus_rx_data, 32'h0102_0304);
    tick(1); bus_rx_pop = 0;
    check("R11 level stays 0", {27'd0, status[28:24]}, 32'd0);
    check("R11 data after empty pop", bus_rx_data, 32'h0102_0304);

    // R2/R8/R11 on the transmit side
    cfg_width = 0; tick(2);
    push_tx(32'h1A5);
    push_tx(32'h2B7);
    check("R2 tx first 8b", sh_tx_data, 32'hA5);
    sh_tx_pop = 1; tick(1);
    check("R2 tx second", sh_tx_data, 32'hB7);
    tick(1);
    tick(1); sh_tx_pop = 0;
    check("R8 no underrun unframed", {31'd0, status[8]}, 32'd0);
    check("R11 tx holds last", sh_tx_data, 32'hB7);
    cfg_framed = 1;
    sh_tx_pop = 1; tick(1); sh_tx_pop = 0;
    check("R8 underrun framed", {31'd0, status[8]}, 32'd1);
    tick(3);
    check("R8 underrun sticky", {31'd0, status[8]}, 32'd1);
    clr_urun = 1; tick(1); clr_urun = 0;
    check("R8 underrun cleared", {31'd0, status[8]}, 32'd0);
    cfg_framed = 0;

    // R7: overflow at capacity 4
    cfg_width = 2; tick(2);
    for (int i = 1; i <= 5; i++) push_rx(32'(i));
    check("R7 level capped", {27'd0, status[28:24]}, 32'd4);
    check("R7 overflow set", {31'd0, status[6]}, 32'd1);
    tick(3);
    check("R7 overflow sticky", {31'd0, status[6]}, 32'd1);
    check("R7 oldest kept", bus_rx_data, 32'd1);
    clr_ovfl = 1; tick(1); clr_ovfl = 0;
    check("R7 overflow cleared", {31'd0, status[6]}, 32'd0);

    // R9
    sh_multi_sync = 1; tick(1); sh_multi_sync = 0;
    check("R9 frame error set", {31'd0, status[12]}, 32'd1);
    tick(2);
    check("R9 frame error sticky", {31'd0, status[12]}, 32'd1);

    // R10
    check("R10 masked fault", {31'd0, irq_fault}, 32'd0);
    en_ferr = 1; tick(1);
    check("R10 enabled fault", {31'd0, irq_fault}, 32'd1);
    en_ferr = 0; en_ovfl = 1; tick(1);
    check("R10 other enable", {31'd0, irq_fault}, 32'd0);
    clr_ferr = 1; en_ferr = 1; tick(1); clr_ferr = 0;
    check("R10 cleared flag", {31'd0, irq_fault}, 32'd0);
    en_ferr = 0; en_ovfl = 0;

    // R12 with data present, R1 tx drop
    cfg_width = 0; tick(2);
    for (int i = 0; i < 3; i++) push_tx(32'(i));
    check("R12 tx before change", {27'd0, status[20:16]}, 32'd3);
    cfg_width = 1; tick(1);
    check("R12 tx flushed", {27'd0, status[20:16]}, 32'd0);
    tick(1);
    for (int i = 0; i < 10; i++) push_tx(32'(i));
    check("R1 tx full at 8", {27'd0, status[20:16]}, 32'd8);
    check("R1 tx drop no flag", {31'd0, status[6]}, 32'd0);

    finish_run();
  end
endmodule